// File: doc/BRIEF.md
# Glitch-Free Output Clock Gating Controller

This block sits behind a clock synthesizer and decides, cycle by cycle, which of its derived output clocks reach the pins. It gates two groups: a set of differential processor clock pairs (true and complement) and a set of single-ended bus clocks, one of which is exempt from the bus stop request. Three asynchronous active-low requests drive it: a processor-clock stop, a bus-clock stop and a power-down. Per-output enable bits from a configuration register hold individual outputs low, and a mode bit decides whether processor pairs other than pair 0 obey the stop request or keep running.

Both source clocks are modelled as even divisions of one fast master clock, so the whole block runs in that domain. Each request passes through a two-flop synchronizer, and every gate state is loaded only on the master edge where its source clock goes low. An output can therefore change only inside a low phase, and every high pulse it produces has the full width of the source's high phase. A stopped processor pair rests with true low and complement high; power-down or a cleared enable drives both legs of a pair low.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `cpu_stop_n` is low, every processor pair that obeys it shows true low and complement high no later than 2 + CPU_DIV master cycles after the request (under four processor-clock periods at the default divider).
- R2: After `cpu_stop_n` returns high, the true leg of pair 0 rises again within 2 + CPU_DIV + CPU_DIV/2 master cycles.
- R3: While `pci_stop_n` is low, every gated bus output is held low no later than 2 + PCI_DIV master cycles after the request; after release, the first high pulse begins within 2 + PCI_DIV + PCI_DIV/2 master cycles.
- R4: Every high pulse on a true processor output lasts exactly CPU_DIV/2 master cycles and every high pulse on a bus output lasts exactly PCI_DIV/2 master cycles; an output only rises together with its source clock.
- R5: The free bus output `pci_free_clk` keeps toggling in step with the bus source while `pci_stop_n` is low, the bus outputs keep running during a processor stop, and the processor pairs keep running during a bus stop.
- R6: With `cpu_hi_free` = 1, pairs 1 and above ignore `cpu_stop_n` and keep running; with `cpu_hi_free` = 0 they stop like pair 0. Pair 0 always obeys the stop.
- R7: An enable bit at 0 (1 = enabled) holds its output low: for a processor pair both true and complement go low; for a bus output the single line goes low. Other outputs are unaffected.
- R8: While `pd_n` is low, all outputs (including complements and the free bus output) are low no later than 2 + PCI_DIV master cycles after the request, and toggling either stop input has no effect; after `pd_n` returns high, all enabled outputs run again.
- R9: While `rst_n` is low every output is low; after release with all enables set and no requests, all outputs toggle.
- R10: While a processor pair is running, its complement is the exact inverse of its true leg in every master cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast master clock from which both source clocks are divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous active-low processor-clock stop request |
| pci_stop_n | input | 1 | Asynchronous active-low bus-clock stop request |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_en | input | N_CPU | Per-pair enable, 1 = enabled |
| pci_en | input | N_PCI | Per gated bus output enable, 1 = enabled |
| pci_free_en | input | 1 | Enable of the free-running bus output, 1 = enabled |
| cpu_hi_free | input | 1 | 1 = pairs 1 and above ignore the processor stop |
| cpu_t | output | N_CPU | True legs of the processor pairs |
| cpu_c | output | N_CPU | Complement legs of the processor pairs |
| pci_clk | output | N_PCI | Gated bus clocks |
| pci_free_clk | output | 1 | Bus clock exempt from the bus stop |

## Verification
A request is seen two master edges after it is driven, and then takes effect at the next falling edge of the affected source clock, so a stop completes within 2 + CPU_DIV or 2 + PCI_DIV master cycles and a restart shows its first rising edge half a source period after that. The bench drives every input on the falling master edge and waits exactly these bounds before opening an observation window, and for restarts it counts the cycles to the first high sample and compares them with the bound. A background monitor measures the length of every high pulse on the true and bus outputs in master cycles, so a truncated or stretched pulse is caught whenever a gate changes. The assertions use saturating counters of how long a request has been held, compared against the same bounds.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  typedef enum logic [1:0] {
    PAIR_OFF  = 2'd0,
    PAIR_HALT = 2'd1,
    PAIR_RUN  = 2'd2
  } pair_mode_e;

  // Next state of a differential pair, chosen at a falling edge of its source.
  function automatic pair_mode_e pair_next_mode(input logic en, input logic pwr_on,
                                                input logic stop_req, input logic exempt);
    if (!en || !pwr_on)          return PAIR_OFF;
    else if (stop_req && !exempt) return PAIR_HALT;
    else                          return PAIR_RUN;
  endfunction

  // Next gate of a single-ended output, chosen at a falling edge of its source.
  function automatic logic single_gate_next(input logic en, input logic pwr_on,
                                            input logic stop_req, input logic exempt);
    return en & pwr_on & (~stop_req | exempt);
  endfunction

endpackage

// File: rtl/csc_divider.sv
module csc_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic src,
  output logic fall_evt
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          wrap;

  assign wrap     = (cnt == CW'(DIV - 1));
  assign cnt_nxt  = wrap ? '0 : cnt + 1'b1;
  // The edge at which this is true is the one where src drops to 0.
  assign fall_evt = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CW'(DIV - 1);
      src <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      src <= (cnt_nxt < CW'(HALF));
    end
  end
endmodule

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  // Reset value 0 means every active-low request reads as asserted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/csc_pair_gate.sv
module csc_pair_gate
  import clk_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic fall_evt,
  input  logic en,
  input  logic pwr_on,
  input  logic stop_req,
  input  logic exempt,
  output logic out_t,
  output logic out_c
);
  pair_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode <= PAIR_OFF;
    else if (fall_evt) mode <= pair_next_mode(en, pwr_on, stop_req, exempt);
  end

  always_comb begin
    unique case (mode)
      PAIR_RUN:  begin out_t = src;  out_c = ~src; end
      PAIR_HALT: begin out_t = 1'b0; out_c = 1'b1; end
      default:   begin out_t = 1'b0; out_c = 1'b0; end
    endcase
  end
endmodule

// File: rtl/csc_single_gate.sv
module csc_single_gate
  import clk_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic fall_evt,
  input  logic en,
  input  logic pwr_on,
  input  logic stop_req,
  input  logic exempt,
  output logic out_clk
);
  logic gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate <= 1'b0;
    else if (fall_evt) gate <= single_gate_next(en, pwr_on, stop_req, exempt);
  end

  assign out_clk = src & gate;
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int unsigned CPU_DIV = 4,
  parameter int unsigned PCI_DIV = 12,
  parameter int unsigned N_CPU   = 3,
  parameter int unsigned N_PCI   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pd_n,
  input  logic [N_CPU-1:0] cpu_en,
  input  logic [N_PCI-1:0] pci_en,
  input  logic             pci_free_en,
  input  logic             cpu_hi_free,
  output logic [N_CPU-1:0] cpu_t,
  output logic [N_CPU-1:0] cpu_c,
  output logic [N_PCI-1:0] pci_clk,
  output logic             pci_free_clk
);
  localparam int unsigned N_REQ = 3;

  // Named internal events, visible to the bound checker.
  logic             cpu_src;
  logic             cpu_fall;
  logic             pci_src;
  logic             pci_fall;
  logic [N_REQ-1:0] req_q;
  logic             pwr_on;
  logic             cpu_stop_req;
  logic             pci_stop_req;

  csc_divider #(.DIV(CPU_DIV)) u_cpu_div (
    .clk(clk), .rst_n(rst_n), .src(cpu_src), .fall_evt(cpu_fall)
  );

  csc_divider #(.DIV(PCI_DIV)) u_pci_div (
    .clk(clk), .rst_n(rst_n), .src(pci_src), .fall_evt(pci_fall)
  );

  csc_sync #(.W(N_REQ)) u_req_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pd_n, pci_stop_n, cpu_stop_n}),
    .q(req_q)
  );

  assign cpu_stop_req = ~req_q[0];
  assign pci_stop_req = ~req_q[1];
  assign pwr_on       =  req_q[2];

  for (genvar i = 0; i < N_CPU; i++) begin : g_pair
    logic exempt;
    if (i == 0) begin : g_lead
      assign exempt = 1'b0;
    end else begin : g_follow
      assign exempt = cpu_hi_free;
    end
    csc_pair_gate u_gate (
      .clk(clk), .rst_n(rst_n), .src(cpu_src), .fall_evt(cpu_fall),
      .en(cpu_en[i]), .pwr_on(pwr_on), .stop_req(cpu_stop_req), .exempt(exempt),
      .out_t(cpu_t[i]), .out_c(cpu_c[i])
    );
  end

  for (genvar j = 0; j < N_PCI; j++) begin : g_bus
    csc_single_gate u_gate (
      .clk(clk), .rst_n(rst_n), .src(pci_src), .fall_evt(pci_fall),
      .en(pci_en[j]), .pwr_on(pwr_on), .stop_req(pci_stop_req), .exempt(1'b0),
      .out_clk(pci_clk[j])
    );
  end

  csc_single_gate u_free_gate (
    .clk(clk), .rst_n(rst_n), .src(pci_src), .fall_evt(pci_fall),
    .en(pci_free_en), .pwr_on(pwr_on), .stop_req(pci_stop_req), .exempt(1'b1),
    .out_clk(pci_free_clk)
  );
endmodule

// File: rtl/clk_stop_ctrl_sva.sv
module clk_stop_ctrl_sva #(
  parameter int unsigned CPU_DIV = 4,
  parameter int unsigned PCI_DIV = 12,
  parameter int unsigned N_CPU   = 3,
  parameter int unsigned N_PCI   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_stop_n,
  input logic             pd_n,
  input logic             pci_free_en,
  input logic [N_CPU-1:0] cpu_en,
  input logic [N_CPU-1:0] cpu_t,
  input logic [N_CPU-1:0] cpu_c,
  input logic [N_PCI-1:0] pci_clk,
  input logic             pci_free_clk,
  input logic             cpu_src,
  input logic             pci_src
);
  localparam int unsigned LAT_CPU = 3 + CPU_DIV;
  localparam int unsigned LAT_PCI = 3 + PCI_DIV;
  localparam int unsigned LIM     = LAT_CPU + LAT_PCI;
  localparam int unsigned CW      = $clog2(LIM + 1);

  logic [CW-1:0] cstop_lo, pd_lo, pd_hi, cen_hi, fen_hi, tw, pw;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] x);
    return (x == CW'(LIM)) ? x : x + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cstop_lo <= '0; pd_lo <= '0; pd_hi <= '0;
      cen_hi   <= '0; fen_hi <= '0; tw <= '0; pw <= '0;
    end else begin
      cstop_lo <= !cpu_stop_n ? sat_inc(cstop_lo) : '0;
      pd_lo    <= !pd_n       ? sat_inc(pd_lo)    : '0;
      pd_hi    <=  pd_n       ? sat_inc(pd_hi)    : '0;
      cen_hi   <=  cpu_en[0]  ? sat_inc(cen_hi)   : '0;
      fen_hi   <=  pci_free_en ? sat_inc(fen_hi)  : '0;
      tw       <=  cpu_t[0]   ? sat_inc(tw)       : '0;
      pw       <=  pci_clk[0] ? sat_inc(pw)       : '0;
    end
  end

  // R1: pair 0 rests true-low / complement-high once the stop has been held long enough
  a_r1_pair0_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (cstop_lo >= CW'(LAT_CPU) && pd_hi >= CW'(LAT_CPU) && cen_hi >= CW'(LAT_CPU))
      |-> (!cpu_t[0] && cpu_c[0]));

  // R8: power-down drives every output low
  a_r8_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_lo >= CW'(LAT_PCI))
      |-> (cpu_t == '0 && cpu_c == '0 && pci_clk == '0 && !pci_free_clk));

  // R5: the free bus output follows its source whenever powered and enabled
  a_r5_free_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_hi >= CW'(LAT_PCI) && fen_hi >= CW'(LAT_PCI)) |-> (pci_free_clk == pci_src));

  // R4: full-width high pulses and rising edges aligned with the source
  a_r4_cpu_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_t[0]) |-> (tw == CW'(CPU_DIV / 2)));

  a_r4_pci_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pci_clk[0]) |-> (pw == CW'(PCI_DIV / 2)));

  a_r4_cpu_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_t[0]) |-> $rose(cpu_src));

  a_r4_pci_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_clk[0]) |-> $rose(pci_src));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_sva #(
  .CPU_DIV(CPU_DIV), .PCI_DIV(PCI_DIV), .N_CPU(N_CPU), .N_PCI(N_PCI)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pd_n(pd_n),
  .pci_free_en(pci_free_en), .cpu_en(cpu_en), .cpu_t(cpu_t), .cpu_c(cpu_c),
  .pci_clk(pci_clk), .pci_free_clk(pci_free_clk),
  .cpu_src(cpu_src), .pci_src(pci_src)
);

// File: tb/clk_stop_ctrl_bench.sv
module clk_stop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPU_DIV = 4;
  localparam int PCI_DIV = 12;
  localparam int N_CPU   = 3;
  localparam int N_PCI   = 7;
  localparam int W       = 2 * N_CPU + N_PCI + 1;
  localparam int T0      = 0;                 // index of cpu_t[i] = T0 + i
  localparam int C0      = N_CPU;             // index of cpu_c[i] = C0 + i
  localparam int P0      = 2 * N_CPU;         // index of pci_clk[j] = P0 + j
  localparam int FR      = W - 1;             // free bus output

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pd_n = 1'b1;
  logic [N_CPU-1:0] cpu_en = '1;
  logic [N_PCI-1:0] pci_en = '1;
  logic             pci_free_en = 1'b1, cpu_hi_free = 1'b0;
  logic [N_CPU-1:0] cpu_t, cpu_c;
  logic [N_PCI-1:0] pci_clk;
  logic             pci_free_clk;
  logic [W-1:0]     obs;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clk_stop_ctrl #(.CPU_DIV(CPU_DIV), .PCI_DIV(PCI_DIV), .N_CPU(N_CPU), .N_PCI(N_PCI))
  u_clk_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pd_n(pd_n), .cpu_en(cpu_en), .pci_en(pci_en), .pci_free_en(pci_free_en),
    .cpu_hi_free(cpu_hi_free), .cpu_t(cpu_t), .cpu_c(cpu_c),
    .pci_clk(pci_clk), .pci_free_clk(pci_free_clk)
  );

  assign obs = {pci_free_clk, pci_clk, cpu_c, cpu_t};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Observe n cycles: which bits rose, were ever high, were ever low.
  task automatic watch(input int n, output logic [W-1:0] rose,
                       output logic [W-1:0] hi, output logic [W-1:0] lo);
    logic [W-1:0] prev;
    rose = '0; hi = '0; lo = '0; prev = obs;
    repeat (n) begin
      @(negedge clk);
      hi   |= obs;
      lo   |= ~obs;
      rose |= obs & ~prev;
      prev  = obs;
    end
  endtask

  // Cycles until bit b is first sampled high, or limit+1 if never.
  task automatic cycles_to_high(input int b, input int limit, output int k);
    k = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (obs[b]) begin k = i; break; end
    end
  endtask

  function automatic int half_width(input int b);
    return (b < N_CPU) ? CPU_DIV / 2 : PCI_DIV / 2;
  endfunction

  // R4: background measurement of every high pulse on true and bus outputs
  int run_len [W];
  always @(negedge clk) begin
    for (int b = 0; b < W; b++) begin
      if (!rst_n || (b >= C0 && b < P0)) run_len[b] = 0;
      else if (obs[b]) run_len[b]++;
      else begin
        if (run_len[b] != 0)
          check(run_len[b] == half_width(b), "R4", $sformatf("pulse width bit %0d", b),
                run_len[b], half_width(b));
        run_len[b] = 0;
      end
    end
  end

  logic [W-1:0] all_run_mask;
  assign all_run_mask = {1'b1, {N_PCI{1'b1}}, {N_CPU{1'b1}}, {N_CPU{1'b1}}};

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(obs == '0, "R9", "outputs low in reset", obs, 0);
    end
    rst_n = 1'b1;
    cycles(3 + 2 * PCI_DIV);
  endtask

  task automatic t_run;
    logic [W-1:0] r, h, l;
    bit comp_ok = 1, free_ok = 1;
    for (int i = 0; i < 3 * PCI_DIV; i++) begin
      @(negedge clk);
      if (cpu_c != ~cpu_t) comp_ok = 0;
      if (pci_free_clk != pci_clk[0]) free_ok = 0;
    end
    check(comp_ok, "R10", "complement inverse of true", {cpu_c, cpu_t}, 0);
    check(free_ok, "R5", "free output in step with bus clocks", pci_free_clk, pci_clk[0]);
    watch(2 * PCI_DIV, r, h, l);
    check(r == all_run_mask, "R9", "all outputs toggle after reset", r, all_run_mask);
  endtask

  task automatic t_cpu_stop;
    logic [W-1:0] r, h, l;
    int k;
    cpu_stop_n = 1'b0;
    cycles(2 + CPU_DIV);
    watch(3 * CPU_DIV, r, h, l);
    check(h[T0 +: N_CPU] == '0, "R1", "true legs stay low", h[T0 +: N_CPU], 0);
    check(l[C0 +: N_CPU] == '0, "R1", "complement legs stay high", l[C0 +: N_CPU], 0);
    check(r[FR:P0] == '1, "R5", "bus outputs run during cpu stop", r[FR:P0], '1);
    cpu_stop_n = 1'b1;
    cycles_to_high(T0, 2 + CPU_DIV + CPU_DIV / 2, k);
    check(k <= 2 + CPU_DIV + CPU_DIV / 2, "R2", "restart latency", k, 2 + CPU_DIV + CPU_DIV / 2);
    cycles(2 * CPU_DIV);
  endtask

  task automatic t_hi_free;
    logic [W-1:0] r, h, l;
    cpu_hi_free = 1'b1;
    cpu_stop_n  = 1'b0;
    cycles(2 + CPU_DIV);
    watch(3 * CPU_DIV, r, h, l);
    check(h[T0] == 1'b0 && l[C0] == 1'b0, "R6", "pair 0 still obeys stop", {h[T0], l[C0]}, 0);
    check(r[T0 + 1 +: N_CPU - 1] == '1, "R6", "upper pairs run free",
          r[T0 + 1 +: N_CPU - 1], '1);
    cpu_stop_n  = 1'b1;
    cpu_hi_free = 1'b0;
    cycles(3 * CPU_DIV);
  endtask

  task automatic t_pci_stop;
    logic [W-1:0] r, h, l;
    int k;
    pci_stop_n = 1'b0;
    cycles(2 + PCI_DIV);
    watch(2 * PCI_DIV, r, h, l);
    check(h[P0 +: N_PCI] == '0, "R3", "gated bus outputs held low", h[P0 +: N_PCI], 0);
    check(r[FR] == 1'b1, "R5", "free output ignores bus stop", r[FR], 1);
    check(r[T0 +: N_CPU] == '1, "R5", "cpu pairs run during bus stop", r[T0 +: N_CPU], '1);
    pci_stop_n = 1'b1;
    cycles_to_high(P0, 2 + PCI_DIV + PCI_DIV / 2, k);
    check(k <= 2 + PCI_DIV + PCI_DIV / 2, "R3", "bus restart latency", k, 2 + PCI_DIV + PCI_DIV / 2);
    cycles(2 * PCI_DIV);
  endtask

  task automatic t_enable;
    logic [W-1:0] r, h, l, off_mask;
    cpu_en[1]   = 1'b0;
    pci_en[3]   = 1'b0;
    pci_free_en = 1'b0;
    off_mask = '0;
    off_mask[T0 + 1] = 1'b1; off_mask[C0 + 1] = 1'b1;
    off_mask[P0 + 3] = 1'b1; off_mask[FR] = 1'b1;
    cycles(PCI_DIV + 1);
    watch(2 * PCI_DIV, r, h, l);
    check((h & off_mask) == '0, "R7", "disabled outputs held low", h & off_mask, 0);
    check(r == (all_run_mask & ~off_mask), "R7", "enabled outputs unaffected",
          r, all_run_mask & ~off_mask);
    cpu_en = '1; pci_en = '1; pci_free_en = 1'b1;
    cycles(PCI_DIV + 1);
    watch(2 * PCI_DIV, r, h, l);
    check(r == all_run_mask, "R7", "outputs resume when enabled", r, all_run_mask);
  endtask

  task automatic t_power_down;
    logic [W-1:0] r1, h1, l1, r2, h2, l2, r3, h3, l3;
    pd_n = 1'b0;
    cycles(2 + PCI_DIV);
    watch(PCI_DIV, r1, h1, l1);
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
    watch(PCI_DIV, r2, h2, l2);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    watch(PCI_DIV, r3, h3, l3);
    check(h1 == '0, "R8", "all outputs low in power-down", h1, 0);
    check((h2 | h3) == '0, "R8", "stop inputs ignored in power-down", h2 | h3, 0);
    pd_n = 1'b1;
    cycles(3 + PCI_DIV);
    watch(2 * PCI_DIV, r1, h1, l1);
    check(r1 == all_run_mask, "R8", "outputs resume after power-down", r1, all_run_mask);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_run();
    t_cpu_stop();
    t_hi_free();
    t_pci_stop();
    t_enable();
    t_power_down();
    cycles(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule